// File: doc/BRIEF.md
# Microprogram Sequencer With Address OR-ing

This block is the control unit of a microprogrammed processor. An 8-bit microinstruction address register selects one word of an internal, constant control store. Each word carries encoded datapath fields: bus source, bus destination, auxiliary latch, ALU function, memory request, adder-input select, wait-for-memory, end of routine. It also carries the fields that decide which word comes next. Those fields are decoded into one-hot enables and strobes for a single-bus datapath. The datapath and the memory live outside this block.

The sequencer has no incrementer. Every word names its successor in an 8-bit next-address field. Two flags can modify that address. The first ORs the instruction's two addressing-mode bits into address bits 4:3, which gives a four-way branch. The second ORs the inverse of the instruction's indirect bit into address bit 0, which skips the indirection step when the operand is direct. A third flag discards the next-address field and takes the start address from a small opcode decoder. That decoder also tests a condition-code bit for conditional branches. When a word requests a wait and the memory has not yet signalled completion, the address register holds, so every strobe of that word stays asserted.

Top module: `micro_seq`

## Requirements
- R1: A synchronous active-high reset sets `uaddr` to 0. At address 0 the outputs are: `src_en`=1 (PC), `dst_en`=5'b00100 (Z), `aux_en`=1 (MAR), `mem_read`=1, `sel_four`=1 and `alu_fn`=0000.
- R2: The fetch runs through addresses 0→1→2→3. At 1 the outputs are `src_en`=4 (Z), `dst_en`=1 (PC), `aux_en`=8 (Y) and `wait_mfc`=1. At 2 they are `src_en`=2 (MDR) and `dst_en`=2 (IR).
- R3: While `wait_mfc`=1 and `mfc`=0, `uaddr` and every output hold their values. After `mfc` rises, the sequence advances on the next clock.
- R4: At address 3 (dispatch), the opcode `ir[15:11]`=1 (add) goes next to octal 100 with `ir[10:9]` ORed into address bits 4:3. This gives 100, 110, 120 or 130 for modes 0 to 3.
- R5: The opcodes 2, 3, 4 and 5 test `cc[0]`, `cc[1]`, `cc[2]` and `cc[3]` respectively. A set bit goes to octal 030, then 031 and 032, with End at 032. A clear bit goes to octal 077.
- R6: A source routine ends by ORing the inverse of `ir[8]` into bit 0 of octal 170. An indirect operand (`ir[8]`=1) visits 170. A direct operand skips to 171.
- R7: The operand tail runs 170→171→172→173. At 171 the outputs are `src_en`=2 and `aux_en`=8. At 173 `end_step`=1, and the next address is 0.
- R8: At most one bit of `src_en`, of `dst_en` and of `aux_en` is set at a time. `mem_read` and `mem_write` are never set together.
- R9: Every control-store entry with no defined routine asserts only `end_step` and returns to 0. Any opcode other than 1 to 5 dispatches to octal 077, whatever its mode bits.
- R10: `alu_fn` carries the 4-bit ALU code: 0001 (subtract) at octal 120 and 0000 (add) at octal 172.
- R11: `reg_out_idx` gives `ir[7:4]` when the bus source is Rsrc and `ir[3:0]` when it is Rdst. `reg_in_idx` does the same for the destination.
- R12: Indexed mode (mode 3) runs octal 130, 131, 132, 133 and 134 before the operand tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir | input | 16 | Current instruction register contents |
| cc | input | 4 | Condition code bits |
| mfc | input | 1 | Memory operation completed |
| uaddr | output | 8 | Current microinstruction address |
| src_en | output | 6 | One-hot bus source: PC, MDR, Z, Rsrc, Rdst, TEMP |
| dst_en | output | 5 | One-hot bus destination: PC, IR, Z, Rsrc, Rdst |
| aux_en | output | 4 | One-hot latch load: MAR, MDR, TEMP, Y |
| alu_fn | output | 4 | ALU function code |
| mem_read | output | 1 | Memory read request |
| mem_write | output | 1 | Memory write request |
| sel_four | output | 1 | ALU A input takes constant 4 instead of Y |
| wait_mfc | output | 1 | Current step waits for memory completion |
| end_step | output | 1 | Last step of a routine |
| reg_out_idx | output | 4 | Register number driving the bus |
| reg_in_idx | output | 4 | Register number loaded from the bus |

## Verification
The bench builds the block with its default parameters: a 16-bit instruction with a 5-bit opcode and a 4-bit condition vector. With those values every opcode class and every mode value can be driven. All four add modes are run with both values of the indirect bit. Each of the four branch opcodes is run with its tested flag set and with it clear, while the other flags hold the opposite value. One fetch is run with memory completion delayed for several cycles, and an undefined opcode with a non-zero mode exercises the default entry.

// File: rtl/micro_seq_pkg.sv
package micro_seq_pkg;

    localparam int UA_W     = 8;
    localparam int CS_DEPTH = 1 << UA_W;
    localparam int RIDX_W   = 4;
    localparam int MODE_W   = 2;
    localparam int IND_BIT  = 2 * RIDX_W;
    localparam int MODE_LSB = IND_BIT + 1;
    localparam int OPC_LSB  = MODE_LSB + MODE_W;
    localparam int UA_MODE_LSB = 3;
    localparam int SRC_N = 6;
    localparam int DST_N = 5;
    localparam int AUX_N = 4;

    localparam logic [UA_W-1:0] UA_FETCH    = 8'o000;
    localparam logic [UA_W-1:0] UA_ADD_BASE = 8'o100;
    localparam logic [UA_W-1:0] UA_BR_TAKEN = 8'o030;
    localparam logic [UA_W-1:0] UA_DEFAULT  = 8'o077;
    localparam logic [UA_W-1:0] UA_OPERAND  = 8'o170;

    localparam int OP_ADD      = 1;
    localparam int OP_BR_FIRST = 2;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_PC, SRC_MDR, SRC_Z, SRC_RSRC, SRC_RDST, SRC_TEMP
    } src_e;

    typedef enum logic [2:0] {
        DST_NONE, DST_PC, DST_IR, DST_Z, DST_RSRC, DST_RDST
    } dst_e;

    typedef enum logic [2:0] {
        AUX_NONE, AUX_MAR, AUX_MDR, AUX_TEMP, AUX_Y
    } aux_e;

    typedef enum logic [3:0] {
        ALU_ADD = 4'b0000, ALU_SUB = 4'b0001, ALU_XOR = 4'b1111
    } alu_e;

    typedef enum logic [1:0] {
        MEM_NONE = 2'b00, MEM_READ = 2'b01, MEM_WRITE = 2'b10
    } mem_e;

    typedef struct packed {
        logic [UA_W-1:0] nxt;
        logic            ormode;
        logic            orind;
        logic            dispatch;
    } seq_t;

    typedef struct packed {
        src_e src;
        dst_e dst;
        aux_e aux;
        alu_e alu;
        mem_e mem;
        logic sel4;
        logic wmfc;
        logic fin;
    } dp_t;

    typedef struct packed {
        seq_t seq;
        dp_t  dp;
    } uinstr_t;

    localparam uinstr_t UI_NOP = '{
        seq: '{nxt: UA_FETCH, ormode: 1'b0, orind: 1'b0, dispatch: 1'b0},
        dp:  '{src: SRC_NONE, dst: DST_NONE, aux: AUX_NONE, alu: ALU_ADD,
               mem: MEM_NONE, sel4: 1'b0, wmfc: 1'b0, fin: 1'b0}
    };

    // Control store contents, one word per address.
    function automatic uinstr_t ucode(input int unsigned a);
        uinstr_t u;
        u = UI_NOP;
        case (a)
            'o000: begin
                u.dp.src = SRC_PC; u.dp.aux = AUX_MAR; u.dp.mem = MEM_READ;
                u.dp.sel4 = 1'b1; u.dp.alu = ALU_ADD; u.dp.dst = DST_Z;
                u.seq.nxt = 8'o001;
            end
            'o001: begin
                u.dp.src = SRC_Z; u.dp.dst = DST_PC; u.dp.aux = AUX_Y;
                u.dp.wmfc = 1'b1; u.seq.nxt = 8'o002;
            end
            'o002: begin
                u.dp.src = SRC_MDR; u.dp.dst = DST_IR; u.seq.nxt = 8'o003;
            end
            'o003: begin
                u.seq.dispatch = 1'b1; u.seq.ormode = 1'b1;
            end
            'o030: begin
                u.dp.src = SRC_PC; u.dp.aux = AUX_Y; u.seq.nxt = 8'o031;
            end
            'o031: begin
                u.dp.src = SRC_TEMP; u.dp.alu = ALU_ADD; u.dp.dst = DST_Z;
                u.seq.nxt = 8'o032;
            end
            'o032: begin
                u.dp.src = SRC_Z; u.dp.dst = DST_PC; u.dp.fin = 1'b1;
            end
            'o100: begin
                u.dp.src = SRC_RSRC; u.dp.aux = AUX_MAR; u.dp.mem = MEM_READ;
                u.dp.wmfc = 1'b1; u.seq.orind = 1'b1; u.seq.nxt = UA_OPERAND;
            end
            'o110: begin
                u.dp.src = SRC_RSRC; u.dp.aux = AUX_MAR; u.dp.mem = MEM_READ;
                u.dp.sel4 = 1'b1; u.dp.alu = ALU_ADD; u.dp.dst = DST_Z;
                u.seq.nxt = 8'o111;
            end
            'o111: begin
                u.dp.src = SRC_Z; u.dp.dst = DST_RSRC; u.dp.wmfc = 1'b1;
                u.seq.orind = 1'b1; u.seq.nxt = UA_OPERAND;
            end
            'o120: begin
                u.dp.src = SRC_RSRC; u.dp.sel4 = 1'b1; u.dp.alu = ALU_SUB;
                u.dp.dst = DST_Z; u.seq.nxt = 8'o121;
            end
            'o121: begin
                u.dp.src = SRC_Z; u.dp.dst = DST_RSRC; u.dp.aux = AUX_MAR;
                u.dp.mem = MEM_READ; u.dp.wmfc = 1'b1;
                u.seq.orind = 1'b1; u.seq.nxt = UA_OPERAND;
            end
            'o130: begin
                u.dp.src = SRC_PC; u.dp.aux = AUX_MAR; u.dp.mem = MEM_READ;
                u.dp.sel4 = 1'b1; u.dp.alu = ALU_ADD; u.dp.dst = DST_Z;
                u.seq.nxt = 8'o131;
            end
            'o131: begin
                u.dp.src = SRC_Z; u.dp.dst = DST_PC; u.dp.wmfc = 1'b1;
                u.seq.nxt = 8'o132;
            end
            'o132: begin
                u.dp.src = SRC_MDR; u.dp.aux = AUX_Y; u.seq.nxt = 8'o133;
            end
            'o133: begin
                u.dp.src = SRC_RSRC; u.dp.alu = ALU_ADD; u.dp.dst = DST_Z;
                u.seq.nxt = 8'o134;
            end
            'o134: begin
                u.dp.src = SRC_Z; u.dp.aux = AUX_MAR; u.dp.mem = MEM_READ;
                u.dp.wmfc = 1'b1; u.seq.orind = 1'b1; u.seq.nxt = UA_OPERAND;
            end
            'o170: begin
                u.dp.src = SRC_MDR; u.dp.aux = AUX_MAR; u.dp.mem = MEM_READ;
                u.dp.wmfc = 1'b1; u.seq.nxt = 8'o171;
            end
            'o171: begin
                u.dp.src = SRC_MDR; u.dp.aux = AUX_Y; u.seq.nxt = 8'o172;
            end
            'o172: begin
                u.dp.src = SRC_RDST; u.dp.alu = ALU_ADD; u.dp.dst = DST_Z;
                u.seq.nxt = 8'o173;
            end
            'o173: begin
                u.dp.src = SRC_Z; u.dp.dst = DST_RDST; u.dp.fin = 1'b1;
            end
            default: begin
                u.dp.fin = 1'b1;
            end
        endcase
        return u;
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
    import micro_seq_pkg::*;
(
    input  logic [UA_W-1:0] addr,
    output uinstr_t         word
);
    uinstr_t rom [CS_DEPTH];

    for (genvar g = 0; g < CS_DEPTH; g++) begin : g_rom
        assign rom[g] = ucode(g);
    end

    assign word = rom[addr];
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import micro_seq_pkg::*;
#(
    parameter int OPC_W = 5,
    parameter int CC_W  = 4
) (
    input  logic [OPC_W-1:0] opc,
    input  logic [CC_W-1:0]  cc,
    output logic [UA_W-1:0]  start
);
    always_comb begin
        start = UA_DEFAULT;
        if (opc == OPC_W'(OP_ADD)) begin
            start = UA_ADD_BASE;
        end
        for (int k = 0; k < CC_W; k++) begin
            if (opc == OPC_W'(OP_BR_FIRST + k)) begin
                start = cc[k] ? UA_BR_TAKEN : UA_DEFAULT;
            end
        end
    end
endmodule

// File: rtl/useq_next.sv
module useq_next
    import micro_seq_pkg::*;
(
    input  seq_t              seq,
    input  logic              wmfc,
    input  logic              mfc,
    input  logic [UA_W-1:0]   start,
    input  logic [MODE_W-1:0] mode,
    input  logic              indirect,
    input  logic [UA_W-1:0]   cur,
    output logic [UA_W-1:0]   nxt_addr
);
    logic [UA_W-1:0] base;
    logic [UA_W-1:0] mode_or;
    logic [UA_W-1:0] ind_or;

    always_comb begin
        base    = seq.dispatch ? start : seq.nxt;
        mode_or = '0;
        ind_or  = '0;
        if (seq.ormode) begin
            mode_or[UA_MODE_LSB +: MODE_W] = mode;
        end
        if (seq.orind) begin
            ind_or[0] = ~indirect;
        end
        if (wmfc && !mfc) begin
            nxt_addr = cur;
        end else begin
            nxt_addr = base | mode_or | ind_or;
        end
    end
endmodule

// File: rtl/useq_decode.sv
module useq_decode
    import micro_seq_pkg::*;
(
    input  dp_t               dp,
    input  logic [RIDX_W-1:0] rsrc_idx,
    input  logic [RIDX_W-1:0] rdst_idx,
    output logic [SRC_N-1:0]  src_en,
    output logic [DST_N-1:0]  dst_en,
    output logic [AUX_N-1:0]  aux_en,
    output logic [3:0]        alu_fn,
    output logic              mem_read,
    output logic              mem_write,
    output logic              sel_four,
    output logic              wait_mfc,
    output logic              end_step,
    output logic [RIDX_W-1:0] reg_out_idx,
    output logic [RIDX_W-1:0] reg_in_idx
);
    always_comb begin
        src_en = '0;
        case (dp.src)
            SRC_PC:   src_en[0] = 1'b1;
            SRC_MDR:  src_en[1] = 1'b1;
            SRC_Z:    src_en[2] = 1'b1;
            SRC_RSRC: src_en[3] = 1'b1;
            SRC_RDST: src_en[4] = 1'b1;
            SRC_TEMP: src_en[5] = 1'b1;
            default:  src_en = '0;
        endcase

        dst_en = '0;
        case (dp.dst)
            DST_PC:   dst_en[0] = 1'b1;
            DST_IR:   dst_en[1] = 1'b1;
            DST_Z:    dst_en[2] = 1'b1;
            DST_RSRC: dst_en[3] = 1'b1;
            DST_RDST: dst_en[4] = 1'b1;
            default:  dst_en = '0;
        endcase

        aux_en = '0;
        case (dp.aux)
            AUX_MAR:  aux_en[0] = 1'b1;
            AUX_MDR:  aux_en[1] = 1'b1;
            AUX_TEMP: aux_en[2] = 1'b1;
            AUX_Y:    aux_en[3] = 1'b1;
            default:  aux_en = '0;
        endcase

        case (dp.src)
            SRC_RSRC: reg_out_idx = rsrc_idx;
            SRC_RDST: reg_out_idx = rdst_idx;
            default:  reg_out_idx = '0;
        endcase

        case (dp.dst)
            DST_RSRC: reg_in_idx = rsrc_idx;
            DST_RDST: reg_in_idx = rdst_idx;
            default:  reg_in_idx = '0;
        endcase
    end

    assign alu_fn    = dp.alu;
    assign mem_read  = (dp.mem == MEM_READ);
    assign mem_write = (dp.mem == MEM_WRITE);
    assign sel_four  = dp.sel4;
    assign wait_mfc  = dp.wmfc;
    assign end_step  = dp.fin;
endmodule

// File: rtl/micro_seq.sv
module micro_seq
    import micro_seq_pkg::*;
#(
    parameter int IR_W = 16,
    parameter int CC_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IR_W-1:0]   ir,
    input  logic [CC_W-1:0]   cc,
    input  logic              mfc,
    output logic [UA_W-1:0]   uaddr,
    output logic [SRC_N-1:0]  src_en,
    output logic [DST_N-1:0]  dst_en,
    output logic [AUX_N-1:0]  aux_en,
    output logic [3:0]        alu_fn,
    output logic              mem_read,
    output logic              mem_write,
    output logic              sel_four,
    output logic              wait_mfc,
    output logic              end_step,
    output logic [RIDX_W-1:0] reg_out_idx,
    output logic [RIDX_W-1:0] reg_in_idx
);
    localparam int OPC_W = IR_W - OPC_LSB;

    uinstr_t         word;
    logic [UA_W-1:0] start;
    logic [UA_W-1:0] nxt_addr;

    useq_store u_store (
        .addr (uaddr),
        .word (word)
    );

    useq_dispatch #(.OPC_W(OPC_W), .CC_W(CC_W)) u_dispatch (
        .opc   (ir[IR_W-1:OPC_LSB]),
        .cc    (cc),
        .start (start)
    );

    useq_next u_next (
        .seq      (word.seq),
        .wmfc     (word.dp.wmfc),
        .mfc      (mfc),
        .start    (start),
        .mode     (ir[MODE_LSB +: MODE_W]),
        .indirect (ir[IND_BIT]),
        .cur      (uaddr),
        .nxt_addr (nxt_addr)
    );

    useq_decode u_decode (
        .dp          (word.dp),
        .rsrc_idx    (ir[RIDX_W +: RIDX_W]),
        .rdst_idx    (ir[0 +: RIDX_W]),
        .src_en      (src_en),
        .dst_en      (dst_en),
        .aux_en      (aux_en),
        .alu_fn      (alu_fn),
        .mem_read    (mem_read),
        .mem_write   (mem_write),
        .sel_four    (sel_four),
        .wait_mfc    (wait_mfc),
        .end_step    (end_step),
        .reg_out_idx (reg_out_idx),
        .reg_in_idx  (reg_in_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            uaddr <= UA_FETCH;
        end else begin
            uaddr <= nxt_addr;
        end
    end
endmodule

// File: rtl/micro_seq_chk.sv
module micro_seq_chk
    import micro_seq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             mfc,
    input logic [UA_W-1:0]  uaddr,
    input logic [SRC_N-1:0] src_en,
    input logic [DST_N-1:0] dst_en,
    input logic [AUX_N-1:0] aux_en,
    input logic             mem_read,
    input logic             mem_write,
    input logic             wait_mfc,
    input logic             end_step
);
    AST_RESET_FETCH: assert property (@(posedge clk) rst |=> (uaddr == UA_FETCH)); // R1

    AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (rst)
        (uaddr == 8'o000) |=> (uaddr == 8'o001)); // R2

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wait_mfc && !mfc) |=> $stable(uaddr)); // R3

    AST_END_RETURN: assert property (@(posedge clk) disable iff (rst)
        end_step |=> (uaddr == UA_FETCH)); // R7

    AST_SRC_EXCL: assert property (@(posedge clk) disable iff (rst) $onehot0(src_en)); // R8
    AST_DST_EXCL: assert property (@(posedge clk) disable iff (rst) $onehot0(dst_en)); // R8
    AST_AUX_EXCL: assert property (@(posedge clk) disable iff (rst) $onehot0(aux_en)); // R8
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_read && mem_write)); // R8
endmodule

bind micro_seq micro_seq_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .mfc       (mfc),
    .uaddr     (uaddr),
    .src_en    (src_en),
    .dst_en    (dst_en),
    .aux_en    (aux_en),
    .mem_read  (mem_read),
    .mem_write (mem_write),
    .wait_mfc  (wait_mfc),
    .end_step  (end_step)
);

// File: tb/test_micro_seq.sv
module test_micro_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ir  = '0;
    logic [3:0]  cc  = '0;
    logic        mfc = 1'b1;

    logic [7:0] uaddr;
    logic [5:0] src_en;
    logic [4:0] dst_en;
    logic [3:0] aux_en;
    logic [3:0] alu_fn;
    logic       mem_read, mem_write, sel_four, wait_mfc, end_step;
    logic [3:0] reg_out_idx, reg_in_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    micro_seq i_micro_seq (
        .clk(clk), .rst(rst), .ir(ir), .cc(cc), .mfc(mfc),
        .uaddr(uaddr), .src_en(src_en), .dst_en(dst_en), .aux_en(aux_en),
        .alu_fn(alu_fn), .mem_read(mem_read), .mem_write(mem_write),
        .sel_four(sel_four), .wait_mfc(wait_mfc), .end_step(end_step),
        .reg_out_idx(reg_out_idx), .reg_in_idx(reg_in_idx)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic excl_chk();
        chk("R8 src exclusive", int'($countones(src_en) <= 1), 1);
        chk("R8 dst exclusive", int'($countones(dst_en) <= 1), 1);
        chk("R8 aux exclusive", int'($countones(aux_en) <= 1), 1);
        chk("R8 read/write exclusive", int'(mem_read && mem_write), 0);
    endtask

    // Compare uaddr against an expected trace, one entry per negedge.
    task automatic walk(input string req, input int s[24], input int n);
        for (int i = 0; i < n; i++) begin
            chk(req, int'(uaddr), s[i]);
            excl_chk();
            case (s[i])
                'o100, 'o110, 'o120: chk("R11 src index", int'(reg_out_idx), int'(ir[7:4]));
                default: ;
            endcase
            if (s[i] == 'o120) chk("R10 sub code", int'(alu_fn), 1);
            if (s[i] == 'o171) begin
                chk("R7 171 source", int'(src_en), 2);
                chk("R7 171 latch", int'(aux_en), 8);
            end
            if (s[i] == 'o172) begin
                chk("R10 add code", int'(alu_fn), 0);
                chk("R11 dst index out", int'(reg_out_idx), int'(ir[3:0]));
            end
            if (s[i] == 'o173) begin
                chk("R11 dst index in", int'(reg_in_idx), int'(ir[3:0]));
                chk("R7 end", int'(end_step), 1);
            end
            if (i < n - 1) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 reset addr", int'(uaddr), 0);
        chk("R1 src PC", int'(src_en), 1);
        chk("R1 dst Z", int'(dst_en), 4);
        chk("R1 aux MAR", int'(aux_en), 1);
        chk("R1 read", int'(mem_read), 1);
        chk("R1 select4", int'(sel_four), 1);
        chk("R1 alu add", int'(alu_fn), 0);
        rst = 1'b0;
    endtask

    task automatic t_fetch_stall();
        ir  = 16'h0000;
        mfc = 1'b0;
        @(negedge clk);
        chk("R2 addr 1", int'(uaddr), 1);
        chk("R2 src Z", int'(src_en), 4);
        chk("R2 dst PC", int'(dst_en), 1);
        chk("R2 aux Y", int'(aux_en), 8);
        chk("R2 wait", int'(wait_mfc), 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R3 hold addr", int'(uaddr), 1);
            chk("R3 hold src", int'(src_en), 4);
        end
        mfc = 1'b1;
        @(negedge clk);
        chk("R2 addr 2", int'(uaddr), 2);
        chk("R2 src MDR", int'(src_en), 2);
        chk("R2 dst IR", int'(dst_en), 2);
        @(negedge clk);
        chk("R2 addr 3", int'(uaddr), 3);
        @(negedge clk);
        chk("R9 default addr", int'(uaddr), 'o077);
        chk("R9 default end", int'(end_step), 1);
        chk("R9 default src", int'(src_en), 0);
        chk("R9 default dst", int'(dst_en), 0);
        chk("R9 default aux", int'(aux_en), 0);
        chk("R9 default read", int'(mem_read), 0);
        @(negedge clk);
        chk("R9 return", int'(uaddr), 0);
    endtask

    task automatic t_add(input int mode, input int ind);
        int s[24];
        int n;
        s = '{default: 0};
        ir = {5'd1, 2'(mode), 1'(ind), 4'(mode + 5), 4'(9 - mode)};
        s[0] = 0; s[1] = 1; s[2] = 2; s[3] = 3; n = 4;
        case (mode)
            0: begin s[n] = 'o100; n++; end
            1: begin s[n] = 'o110; s[n+1] = 'o111; n += 2; end
            2: begin s[n] = 'o120; s[n+1] = 'o121; n += 2; end
            default: begin
                // R12 indexed path
                for (int k = 0; k < 5; k++) s[n+k] = 'o130 + k;
                n += 5;
            end
        endcase
        if (ind != 0) begin s[n] = 'o170; n++; end
        s[n] = 'o171; s[n+1] = 'o172; s[n+2] = 'o173; s[n+3] = 0; n += 4;
        walk("R4 R6 R7 R12 add trace", s, n);
    endtask

    task automatic t_branch(input int k, input int taken);
        int s[24];
        int n;
        s  = '{default: 0};
        ir = {5'(2 + k), 11'h0};
        cc = (taken != 0) ? 4'(1 << k) : ~4'(1 << k);
        s[0] = 0; s[1] = 1; s[2] = 2; s[3] = 3; n = 4;
        if (taken != 0) begin
            s[4] = 'o030; s[5] = 'o031; s[6] = 'o032; s[7] = 0; n = 8;
        end else begin
            s[4] = 'o077; s[5] = 0; n = 6;
        end
        walk("R5 branch trace", s, n);
    endtask

    task automatic t_unknown();
        int s[24];
        s  = '{default: 0};
        ir = {5'd20, 2'd1, 1'b0, 8'h00};
        s[0] = 0; s[1] = 1; s[2] = 2; s[3] = 3; s[4] = 'o077; s[5] = 0;
        walk("R9 unknown opcode trace", s, 6);
    endtask

    initial begin
        t_reset();
        t_fetch_stall();
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 2; i++) t_add(m, i);
        end
        for (int k = 0; k < 4; k++) begin
            t_branch(k, 1);
            t_branch(k, 0);
        end
        t_unknown();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule